// File: doc/BRIEF.md
# Multi-Lane PHY Reset Sequencer

This block runs in the control clock domain. It takes a group of PHY lanes, and the PLLs that clock them, from power-on or lock loss to a ready state in a fixed order. It sees the PLLs and lanes only through their status flags. It drives the lane resets, the PLL clock-output enable and the voltage/temperature tracking (VTC) enables. When it raises a done flag, it also opens the datapath read and write enables.

The sequence is as follows. The block waits for every PLL feedback lock and then releases the lane resets. It counts a fixed interval and then enables the PLL PHY clock. It then waits for all lanes to report delay-ready, seen through a synchronizer. Source-synchronous mode has two extra steps: the block may turn on lane VTC tracking, and it then waits for all lanes to report PHY-ready. Serial mode leaves out both steps. In either mode a short settle count follows, and the block waits for every PLL's main lock before it declares completion. If any feedback lock drops at any point, the block returns to the reset values and starts over.

Top module: `lane_rst_seq`

## Requirements
- R1: Reset state: every lane global reset is 1, the PLL clock-output enable is 0, lane VTC is 0, done is 0, and the read and write enables are 0. This holds after power-on and whenever any feedback lock is low.
- R2: The lane global, transmit and receive resets go to 0 at the first clock edge at which all feedback locks are seen high together.
- R3: The PLL clock-output enable rises exactly 64 clock edges after the edge that released the resets.
- R4: The lane delay-ready flags are combined with an AND and pass through a two-flop synchronizer. With all flags high, the sequence advances at the third clock edge, and not sooner.
- R5: In source-synchronous mode (`cfg_serial`=0), lane VTC rises on all lanes at the edge where the combined delay-ready takes effect. This happens only if `cfg_vtc_used`=1 and `cfg_ref_fast`=1. Otherwise VTC stays 0.
- R6: In source-synchronous mode, the block waits for all PHY-ready flags, which pass through a two-flop synchronizer. It then counts 16 cycles, and done rises 20 edges after the last PHY-ready flag goes high.
- R7: In serial mode (`cfg_serial`=1), lane VTC stays 0 and PHY-ready is ignored. Done rises 20 edges after the last delay-ready flag goes high.
- R8: Done rises only while every PLL main lock is high. If a main lock is low after the settle count, the block waits, and done rises one edge after all main locks are high.
- R9: A drop of any feedback lock returns all outputs to the R1 values at the next edge. This includes a drop in the same cycle the 64-cycle count ends.
- R10: For each lane whose bit in `cfg_rst_tie_low` is 1, the transmit and receive resets stay 0 at all times. Its global reset is not affected.
- R11: `phy_wr_en` and `phy_rd_en` are 0 until done and 1 while done is 1. The per-lane transmit and receive VTC enables stay 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| pll_lock_fb | input | NUM_PLL | Per-PLL feedback lock |
| pll_lock | input | NUM_PLL | Per-PLL main lock |
| lane_dly_rdy | input | NUM_LANE | Per-lane delay-ready |
| lane_phy_rdy | input | NUM_LANE | Per-lane PHY-ready |
| cfg_serial | input | 1 | 1 = serial mode, 0 = source-synchronous mode |
| cfg_vtc_used | input | 1 | VTC tracking is used |
| cfg_ref_fast | input | 1 | Reference clock is at least 500 MHz |
| cfg_rst_tie_low | input | NUM_LANE | Per-lane mask: hold the transmit and receive resets low |
| lane_rst | output | NUM_LANE | Per-lane global reset |
| lane_tx_rst | output | NUM_LANE | Per-lane transmit reset |
| lane_rx_rst | output | NUM_LANE | Per-lane receive reset |
| pll_phyclk_en | output | 1 | PLL PHY clock-output enable, shared by all PLLs |
| lane_vtc_en | output | NUM_LANE | Per-lane VTC tracking enable |
| lane_tx_vtc_en | output | NUM_LANE | Per-lane transmit VTC enable |
| lane_rx_vtc_en | output | NUM_LANE | Per-lane receive VTC enable |
| phy_wr_en | output | 1 | Datapath write enable |
| phy_rd_en | output | 1 | Datapath read enable |
| seq_done | output | 1 | Sequence complete |

## Verification
A feedback-lock loss can land on the same edge as the end of the 64-cycle count. In that case the restart must win, and the clock enable must stay low. The bench drops one feedback lock on the exact negative edge before the terminal edge. It then checks that the next sample shows the resets high and the clock enable still low. Lock loss after done is also exercised. Random mode, mask and gap choices make delay-ready and PHY-ready arrive at varying points relative to the counters.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_PLL_WAIT   = 3'd1,
    ST_DLY_WAIT   = 3'd2,
    ST_PHY_WAIT   = 3'd3,
    ST_SETTLE     = 3'd4,
    ST_LOCK_CHECK = 3'd5,
    ST_DONE       = 3'd6
  } seq_state_t;
endpackage

// File: rtl/lrs_sync.sv
// Multi-flop synchronizer for a single level signal; STAGES must be 2 or more.
module lrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lrs_wait_cnt.sv
// Saturating up-counter, cleared synchronously on clr.
module lrs_wait_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt != '1)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
  import lrs_pkg::*;
#(
  parameter int NUM_PLL     = 2,
  parameter int NUM_LANE    = 4,
  parameter int PLL_WAIT    = 64,
  parameter int SETTLE_WAIT = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PLL-1:0]  pll_lock_fb,
  input  logic [NUM_PLL-1:0]  pll_lock,
  input  logic [NUM_LANE-1:0] lane_dly_rdy,
  input  logic [NUM_LANE-1:0] lane_phy_rdy,
  input  logic                cfg_serial,
  input  logic                cfg_vtc_used,
  input  logic                cfg_ref_fast,
  input  logic [NUM_LANE-1:0] cfg_rst_tie_low,
  output logic [NUM_LANE-1:0] lane_rst,
  output logic [NUM_LANE-1:0] lane_tx_rst,
  output logic [NUM_LANE-1:0] lane_rx_rst,
  output logic                pll_phyclk_en,
  output logic [NUM_LANE-1:0] lane_vtc_en,
  output logic [NUM_LANE-1:0] lane_tx_vtc_en,
  output logic [NUM_LANE-1:0] lane_rx_vtc_en,
  output logic                phy_wr_en,
  output logic                phy_rd_en,
  output logic                seq_done
);
  localparam int MAX_WAIT = (PLL_WAIT > SETTLE_WAIT) ? PLL_WAIT : SETTLE_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] PLL_TC    = CNT_W'(PLL_WAIT - 1);
  localparam logic [CNT_W-1:0] SETTLE_TC = CNT_W'(SETTLE_WAIT - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             fb_all, lock_all, dly_ok, phy_ok;
  logic             in_reset, vtc_on;

  assign fb_all   = &pll_lock_fb;
  assign lock_all = &pll_lock;

  lrs_sync #(.STAGES(SYNC_STAGES)) u_dly_sync (
    .clk(clk), .rst_n(rst_n), .d(&lane_dly_rdy), .q(dly_ok)
  );

  lrs_sync #(.STAGES(SYNC_STAGES)) u_phy_sync (
    .clk(clk), .rst_n(rst_n), .d(&lane_phy_rdy), .q(phy_ok)
  );

  lrs_wait_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .cnt(cnt_q)
  );

  // Next-state logic: feedback-lock loss overrides every other branch.
  always_comb begin
    state_d = state_q;
    if (!fb_all) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:      state_d = ST_PLL_WAIT;
        ST_PLL_WAIT:   if (cnt_q == PLL_TC) state_d = ST_DLY_WAIT;
        ST_DLY_WAIT:   if (dly_ok) state_d = cfg_serial ? ST_SETTLE : ST_PHY_WAIT;
        ST_PHY_WAIT:   if (phy_ok) state_d = ST_SETTLE;
        ST_SETTLE:     if (cnt_q == SETTLE_TC) state_d = ST_LOCK_CHECK;
        ST_LOCK_CHECK: if (lock_all) state_d = ST_DONE;
        ST_DONE:       state_d = ST_DONE;
        default:       state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign in_reset      = (state_q == ST_RESET);
  assign pll_phyclk_en = !in_reset && (state_q != ST_PLL_WAIT);
  assign seq_done      = (state_q == ST_DONE);
  assign phy_wr_en     = seq_done;
  assign phy_rd_en     = seq_done;
  assign vtc_on        = !cfg_serial && cfg_vtc_used && cfg_ref_fast &&
                         (state_q inside {ST_PHY_WAIT, ST_SETTLE, ST_LOCK_CHECK, ST_DONE});

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    assign lane_rst[g]       = in_reset;
    assign lane_tx_rst[g]    = in_reset && !cfg_rst_tie_low[g];
    assign lane_rx_rst[g]    = in_reset && !cfg_rst_tie_low[g];
    assign lane_vtc_en[g]    = vtc_on;
    assign lane_tx_vtc_en[g] = 1'b1;
    assign lane_rx_vtc_en[g] = 1'b1;
  end

  AST_LOSS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_all |=> (lane_rst == '1) && !pll_phyclk_en && !seq_done && (lane_vtc_en == '0)); // R9
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lane_rst[0]) |-> $past(fb_all)); // R2
  AST_CLKEN_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_phyclk_en) |-> $past(cnt_q) == PLL_TC); // R3
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PLL_WAIT) |-> (cnt_q < CNT_W'(PLL_WAIT))); // R3
  AST_VTC_AFTER_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_vtc_en[0]) |-> $past(dly_ok)); // R5
  AST_DONE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(lock_all)); // R8
endmodule

// File: tb/sim_lane_rst_seq.sv
module sim_lane_rst_seq;
  localparam int NP = 2;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pll_lock_fb = '0, pll_lock = '0;
  logic [NL-1:0] lane_dly_rdy = '0, lane_phy_rdy = '0, cfg_rst_tie_low = '0;
  logic          cfg_serial = 1'b0, cfg_vtc_used = 1'b0, cfg_ref_fast = 1'b0;
  logic [NL-1:0] lane_rst, lane_tx_rst, lane_rx_rst, lane_vtc_en, lane_tx_vtc_en, lane_rx_vtc_en;
  logic          pll_phyclk_en, phy_wr_en, phy_rd_en, seq_done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lane_rst_seq #(.NUM_PLL(NP), .NUM_LANE(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .pll_lock_fb(pll_lock_fb), .pll_lock(pll_lock),
    .lane_dly_rdy(lane_dly_rdy), .lane_phy_rdy(lane_phy_rdy), .cfg_serial(cfg_serial),
    .cfg_vtc_used(cfg_vtc_used), .cfg_ref_fast(cfg_ref_fast), .cfg_rst_tie_low(cfg_rst_tie_low),
    .lane_rst(lane_rst), .lane_tx_rst(lane_tx_rst), .lane_rx_rst(lane_rx_rst),
    .pll_phyclk_en(pll_phyclk_en), .lane_vtc_en(lane_vtc_en), .lane_tx_vtc_en(lane_tx_vtc_en),
    .lane_rx_vtc_en(lane_rx_vtc_en), .phy_wr_en(phy_wr_en), .phy_rd_en(phy_rd_en),
    .seq_done(seq_done)
  );

  function automatic logic [NL-1:0] exp_vtc(bit ser, bit used, bit fast);
    return (!ser && used && fast) ? '1 : '0;
  endfunction

  function automatic logic [NL-1:0] exp_txrx_rst(logic [NL-1:0] mask, bit held);
    return held ? ~mask : '0;
  endfunction

  function automatic int exp_done_lat();
    return 2 + 1 + 16 + 1;  // sync flops, transition edge, settle, lock check
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // abort: 0 none, 1 lock loss on the edge the 64-count ends, 2 lock loss after done
  task automatic scenario(bit ser, bit used, bit fast, logic [NL-1:0] mask, bit late,
                          int dly_gap, int phy_gap, int abort);
    int k;
    @(negedge clk);
    pll_lock_fb = '0; lane_dly_rdy = '0; lane_phy_rdy = '0;
    pll_lock = late ? '0 : '1;
    cfg_serial = ser; cfg_vtc_used = used; cfg_ref_fast = fast; cfg_rst_tie_low = mask;
    repeat (4) @(negedge clk);
    chk(lane_rst == '1, "R1 lane_rst", int'(lane_rst), int'(4'hF));
    chk(!pll_phyclk_en && !seq_done && lane_vtc_en == '0, "R1 enables",
        int'(pll_phyclk_en) + int'(seq_done), 0);
    chk(!phy_wr_en && !phy_rd_en, "R11 rw low", int'(phy_wr_en), 0);
    chk(lane_tx_vtc_en == '1 && lane_rx_vtc_en == '1, "R11 txrx vtc",
        int'(lane_tx_vtc_en), int'(4'hF));
    chk(lane_tx_rst == exp_txrx_rst(mask, 1'b1), "R10 tx_rst", int'(lane_tx_rst),
        int'(exp_txrx_rst(mask, 1'b1)));
    chk(lane_rx_rst == exp_txrx_rst(mask, 1'b1), "R10 rx_rst", int'(lane_rx_rst),
        int'(exp_txrx_rst(mask, 1'b1)));
    pll_lock_fb = 2'b01;
    @(negedge clk);
    chk(lane_rst == '1, "R2 partial lock", int'(lane_rst), int'(4'hF));
    pll_lock_fb = '1;
    @(negedge clk);
    chk(lane_rst == '0 && lane_tx_rst == '0 && lane_rx_rst == '0, "R2 release",
        int'(lane_rst), 0);
    if (abort == 1) begin
      repeat (63) @(negedge clk);
      chk(!pll_phyclk_en, "R3 en early", int'(pll_phyclk_en), 0);
      pll_lock_fb = 2'b10;
      @(negedge clk);
      chk(!pll_phyclk_en && lane_rst == '1, "R9 loss vs count", int'(pll_phyclk_en), 0);
      return;
    end
    k = 0;
    while (!pll_phyclk_en && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(k == 64, "R3 clken delay", k, 64);
    repeat (dly_gap) @(negedge clk);
    lane_dly_rdy = '1;
    lane_phy_rdy = ser ? 4'h0 : 4'h0;
    repeat (2) @(negedge clk);
    chk(lane_vtc_en == '0, "R4 sync latency", int'(lane_vtc_en), 0);
    @(negedge clk);
    chk(lane_vtc_en == exp_vtc(ser, used, fast), ser ? "R7 vtc" : "R5 vtc",
        int'(lane_vtc_en), int'(exp_vtc(ser, used, fast)));
    k = exp_done_lat() - 3;
    if (!ser) begin
      repeat (phy_gap) @(negedge clk);
      chk(!seq_done, "R6 phy wait", int'(seq_done), 0);
      lane_phy_rdy = '1;
      k = exp_done_lat();
    end
    if (late) begin
      repeat (k + 10) @(negedge clk);
      chk(!seq_done, "R8 no lock", int'(seq_done), 0);
      pll_lock = '1;
      @(negedge clk);
      chk(seq_done, "R8 late lock", int'(seq_done), 1);
    end else begin
      repeat (k - 1) @(negedge clk);
      chk(!seq_done, ser ? "R7 early" : "R6 early", int'(seq_done), 0);
      @(negedge clk);
      chk(seq_done, ser ? "R7 done" : "R6 done", int'(seq_done), 1);
    end
    chk(phy_wr_en && phy_rd_en, "R11 rw high", int'(phy_wr_en), 1);
    chk(lane_vtc_en == exp_vtc(ser, used, fast), "R5 vtc hold", int'(lane_vtc_en),
        int'(exp_vtc(ser, used, fast)));
    if (abort == 2) begin
      pll_lock_fb = 2'b10;
      @(negedge clk);
      chk(!seq_done && lane_rst == '1 && !pll_phyclk_en && lane_vtc_en == '0,
          "R9 loss after done", int'(seq_done), 0);
      chk(lane_tx_rst == exp_txrx_rst(mask, 1'b1), "R10 tx_rst restart",
          int'(lane_tx_rst), int'(exp_txrx_rst(mask, 1'b1)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(lane_rst == '1 && !pll_phyclk_en, "R1 power-on", int'(lane_rst), int'(4'hF));
    rst_n = 1'b1;
    scenario(1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 3, 5, 0);
    scenario(1'b1, 1'b1, 1'b1, 4'b0001, 1'b0, 0, 0, 2);
    scenario(1'b0, 1'b1, 1'b0, 4'b1010, 1'b0, 7, 0, 0);
    scenario(1'b0, 1'b0, 1'b1, 4'b0000, 1'b1, 1, 2, 2);
    scenario(1'b0, 1'b1, 1'b1, 4'b0001, 1'b0, 0, 0, 1);
    for (int i = 0; i < 16; i++) begin
      int unsigned r = $urandom;
      scenario(r[0], r[1], r[2], r[6:3], r[7], int'(r[12:8]), int'(r[17:13]),
               (r[19:18] == 2'd0) ? 1 : ((r[19:18] == 2'd1) ? 2 : 0));
    end
    summary();
  end
endmodule